// File: doc/BRIEF.md
# Channel Synthesizer Digital Loop Core

This block holds the digital half of a channelized integer-N frequency synthesizer. The reference clock runs the whole block. A reference divider turns it into comparison ticks at a rate picked by a step-select pin and a transmit/receive pin. The feedback signal comes from the downmixed oscillator. The block synchronizes it, detects its rising edges and divides them by a 9-bit binary channel code N. A two-flop phase/frequency detector compares the two tick streams and drives mutually exclusive pump-up and pump-down pulses to an external loop filter.

A lock qualifier watches the width of every correction pulse. It declares lock only after a run of clean comparison periods. It drops lock as soon as a pulse grows too wide. Transmission is inhibited whenever the loop is not locked or the channel code is illegal. A new channel code is taken up only when the feedback divider reaches its terminal count, so a channel change never produces a short or torn division period.

Top module: `chan_synth_core`

## Requirements
- R1: With step_sel_i high, the comparison period is REF_BASE reference clocks (1024 by default, giving 10 kHz from 10.24 MHz), whatever the level of txrx_ni.
- R2: With step_sel_i low and txrx_ni high (receive), the comparison period is 2*REF_BASE reference clocks.
- R3: With step_sel_i low and txrx_ni low (transmit), the comparison period is 4*REF_BASE reference clocks.
- R4: The feedback divider emits one tick per N rising edges of fb_i, with N read as unsigned binary from n_code_i (2..511). A changed N takes effect at the next terminal count.
- R5: up_o pulses when the reference tick leads and dn_o pulses when the feedback tick leads. With the feedback rate slower, only up_o is ever high. With it faster, only dn_o is ever high. The two are never high together.
- R6: lock_o rises only after LOCK_CYCLES (16) consecutive comparison ticks during which no correction pulse reached lock_thr_i clocks, so it stays low for at least 16 comparison periods after reset.
- R7: A correction pulse whose width reaches lock_thr_i clocks clears lock_o on the following clock.
- R8: lock_no is always the complement of lock_o.
- R9: inhibit_o is high whenever lock_o is low or the channel code is illegal. After reset it is high, lock_o is low, and up_o and dn_o are low.
- R10: A channel code of 0 or 1 is illegal. It holds the feedback divider in reset so that no feedback tick (and no dn_o pulse) occurs, forces lock_o low and raises inhibit_o. The loop relocks once a legal code returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (crystal oscillator) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fb_i | input | 1 | Downmixed oscillator feedback, sampled by clk_i |
| n_code_i | input | 9 | Channel divide value N, unsigned binary |
| step_sel_i | input | 1 | High: base step; low: half step |
| txrx_ni | input | 1 | Low = transmit, high = receive |
| lock_thr_i | input | 8 | Pulse-width limit for lock, in reference clocks |
| up_o | output | 1 | Pump-up correction pulse |
| dn_o | output | 1 | Pump-down correction pulse |
| lock_o | output | 1 | Loop locked, active high |
| lock_no | output | 1 | Loop locked, active low |
| inhibit_o | output | 1 | Transmit inhibit, active high |

## Verification
The bench acts as a digital oscillator. It produces the feedback with a fixed nominal period and can bend its phase in response to up_o and dn_o, so the loop can be closed or opened. With the loop closed, lock is reached only when N times the feedback period equals the selected comparison period. Locking at N = 2, 4 and 8 for the three step settings therefore tells the three reference ratios apart. With the loop open and a mismatched N, the bench checks which pulse polarity appears and that lock is lost, once for a slower and once for a faster feedback. Illegal codes 0 and 1 are checked for inhibit and for a silent dn_o, and a legal code afterwards is checked to bring lock back.

// File: rtl/chan_synth_pkg.sv
package chan_synth_pkg;
  localparam int unsigned CODE_W = 9;

  typedef enum logic [1:0] {
    STEP_FULL    = 2'd0,
    STEP_HALF    = 2'd1,
    STEP_QUARTER = 2'd2
  } step_e;

  function automatic step_e step_decode(input logic step_sel, input logic txrx_n);
    if (step_sel)    return STEP_FULL;
    else if (txrx_n) return STEP_HALF;
    else             return STEP_QUARTER;
  endfunction
endpackage

// File: rtl/ref_divider.sv
module ref_divider
  import chan_synth_pkg::*;
#(
  parameter int unsigned REF_BASE = 1024
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  step_e step_i,
  output logic  tick_o
);
  localparam int unsigned CW = $clog2(REF_BASE * 4);
  localparam logic [CW-1:0] LOAD_FULL    = CW'(REF_BASE - 1);
  localparam logic [CW-1:0] LOAD_HALF    = CW'(REF_BASE * 2 - 1);
  localparam logic [CW-1:0] LOAD_QUARTER = CW'(REF_BASE * 4 - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  always_comb begin
    unique case (step_i)
      STEP_HALF:    load_val = LOAD_HALF;
      STEP_QUARTER: load_val = LOAD_QUARTER;
      default:      load_val = LOAD_FULL;
    endcase
  end

  // ratio is sampled only at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LOAD_FULL;
      tick_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= load_val;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - CW'(1);
      tick_o <= 1'b0;
    end
  end

  // R1
  ref_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o)
    else $error("ref_gap_chk");
endmodule

// File: rtl/fb_divider.sv
module fb_divider
  import chan_synth_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fb_i,
  input  logic [CODE_W-1:0] n_i,
  output logic              illegal_o,
  output logic              tick_o
);
  logic [2:0]        sync_q;
  logic              edge_w;
  logic [CODE_W-1:0] cnt_q;

  assign illegal_o = (n_i < CODE_W'(2));
  assign edge_w    = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], fb_i};
  end

  // N reloaded only on terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (illegal_o) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (edge_w) begin
      if (cnt_q == '0) begin
        cnt_q  <= n_i - CODE_W'(1);
        tick_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - CODE_W'(1);
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end

  // R10
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !tick_o)
    else $error("illegal_hold_chk");

  // R4
  tick_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(sync_q[1] && !sync_q[2]))
    else $error("tick_edge_chk");
endmodule

// File: rtl/phase_detector.sv
module phase_detector (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic fb_tick_i,
  output logic up_o,
  output logic dn_o,
  output logic active_o
);
  logic up_q, dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_q && dn_q) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | ref_tick_i;
      dn_q <= dn_q | fb_tick_i;
    end
  end

  assign up_o     = up_q & ~dn_q;
  assign dn_o     = dn_q & ~up_q;
  assign active_o = up_q | dn_q;

  // R5
  ref_sets_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_tick_i && !up_q && !dn_q) |=> up_q)
    else $error("ref_sets_up_chk");

  // R5
  fb_sets_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_tick_i && !up_q && !dn_q) |=> dn_q)
    else $error("fb_sets_dn_chk");
endmodule

// File: rtl/lock_detector.sv
module lock_detector #(
  parameter int unsigned THR_W       = 8,
  parameter int unsigned LOCK_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             active_i,
  input  logic             illegal_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             lock_o
);
  localparam int unsigned GW = $clog2(LOCK_CYCLES);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_CYCLES - 1);

  logic [THR_W-1:0] width_q;
  logic [GW-1:0]    good_q;
  logic             wide_w;

  assign wide_w = (width_q >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                width_q <= '0;
    else if (!active_i)         width_q <= '0;
    else if (width_q != '1)     width_q <= width_q + THR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      lock_o <= 1'b0;
    end else if (illegal_i || wide_w) begin
      good_q <= '0;
      lock_o <= 1'b0;
    end else if (ref_tick_i) begin
      if (good_q == GOOD_LAST) lock_o <= 1'b1;
      else                     good_q <= good_q + GW'(1);
    end
  end

  // R7
  wide_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_w |=> !lock_o)
    else $error("wide_unlock_chk");

  // R6
  lock_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(ref_tick_i))
    else $error("lock_on_tick_chk");

  // R10
  illegal_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_i |=> !lock_o)
    else $error("illegal_unlock_chk");
endmodule

// File: rtl/chan_synth_core.sv
module chan_synth_core
  import chan_synth_pkg::*;
#(
  parameter int unsigned REF_BASE    = 1024,
  parameter int unsigned THR_W       = 8,
  parameter int unsigned LOCK_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fb_i,
  input  logic [8:0]       n_code_i,
  input  logic             step_sel_i,
  input  logic             txrx_ni,
  input  logic [THR_W-1:0] lock_thr_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             lock_o,
  output logic             lock_no,
  output logic             inhibit_o
);
  step_e step_w;
  logic  ref_tick, fb_tick, illegal, active, lock_q;

  assign step_w = step_decode(step_sel_i, txrx_ni);

  ref_divider #(.REF_BASE(REF_BASE)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_w),
    .tick_o (ref_tick)
  );

  fb_divider u_fb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fb_i      (fb_i),
    .n_i       (n_code_i),
    .illegal_o (illegal),
    .tick_o    (fb_tick)
  );

  phase_detector u_pfd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick),
    .fb_tick_i  (fb_tick),
    .up_o       (up_o),
    .dn_o       (dn_o),
    .active_o   (active)
  );

  lock_detector #(.THR_W(THR_W), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick),
    .active_i   (active),
    .illegal_i  (illegal),
    .thr_i      (lock_thr_i),
    .lock_o     (lock_q)
  );

  assign lock_o    = lock_q;
  assign lock_no   = ~lock_q;
  assign inhibit_o = ~lock_q | illegal;

  // R9
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> inhibit_o)
    else $error("inhibit_chk");
endmodule

// File: tb/chan_synth_core_test.sv
module chan_synth_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fb = 1'b0;
  logic [8:0] n_code = 9'd2;
  logic       step_sel = 1'b1;
  logic       txrx_n = 1'b1;
  logic [7:0] thr = 8'd8;
  logic       up, dn, lock, lock_n, inhibit;

  int checks = 0, errors = 0;
  int up_cnt = 0, dn_cnt = 0, both_cnt = 0, cmp_bad = 0;
  int fb_cnt = 0, fb_adv = 1;
  bit fb_run = 0, corr_en = 0, done = 0;

  always #10 clk = ~clk;

  chan_synth_core #(.REF_BASE(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fb_i(fb), .n_code_i(n_code),
    .step_sel_i(step_sel), .txrx_ni(txrx_n), .lock_thr_i(thr),
    .up_o(up), .dn_o(dn), .lock_o(lock), .lock_no(lock_n), .inhibit_o(inhibit)
  );

  // behavioral oscillator: nominal feedback period 8 clocks, phase bent by pulses
  always @(negedge clk) begin
    if (fb_run) begin
      fb_adv = 1;
      if (corr_en && up) fb_adv = 2;
      else if (corr_en && dn) fb_adv = 0;
      fb_cnt = fb_cnt + fb_adv;
      if (fb_cnt >= 4) begin
        fb_cnt = fb_cnt - 4;
        fb = ~fb;
      end
    end
    if (up) up_cnt++;
    if (dn) dn_cnt++;
    if (up && dn) both_cnt++;
    if (lock_n !== ~lock) cmp_bad++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    up_cnt = 0; dn_cnt = 0; both_cnt = 0;
  endtask

  task automatic t_reset();
    wait_clk(3);
    check(up == 0 && dn == 0, "R9 reset pulses", {up, dn}, 0);
    check(lock == 0, "R9 reset lock", lock, 0);
    check(inhibit == 1, "R9 reset inhibit", inhibit, 1);
    check(lock_n == 1, "R8 reset lock_no", lock_n, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_base_lock();
    step_sel = 1; txrx_n = 1; n_code = 9'd2; corr_en = 1; fb_run = 1;
    wait_clk(200);
    check(lock == 0, "R6 no early lock", lock, 0);
    wait_clk(2000);
    check(lock == 1, "R1 R6 lock at base ratio N=2", lock, 1);
    check(inhibit == 0, "R9 inhibit released", inhibit, 0);
    clear_counts();
    wait_clk(500);
    check(both_cnt == 0, "R5 exclusive pulses", both_cnt, 0);
    check(lock == 1, "R6 lock held", lock, 1);
  endtask

  task automatic t_tx_ignored();
    txrx_n = 0;
    wait_clk(500);
    check(lock == 1, "R1 txrx ignored at base step", lock, 1);
    txrx_n = 1;
  endtask

  task automatic t_fast_fb();
    corr_en = 0; step_sel = 0; txrx_n = 1;
    wait_clk(100);
    check(lock == 0, "R7 R2 unlock on mismatch", lock, 0);
    check(inhibit == 1, "R9 inhibit when unlocked", inhibit, 1);
    clear_counts();
    wait_clk(300);
    check(dn_cnt > 0, "R5 fast feedback gives dn", dn_cnt, 1);
    check(up_cnt == 0, "R5 fast feedback no up", up_cnt, 0);
  endtask

  task automatic t_half_lock();
    n_code = 9'd4; corr_en = 1;
    wait_clk(2500);
    check(lock == 1, "R2 R4 lock at half step N=4", lock, 1);
  endtask

  task automatic t_slow_fb();
    corr_en = 0; step_sel = 1;
    wait_clk(100);
    check(lock == 0, "R7 unlock slow feedback", lock, 0);
    clear_counts();
    wait_clk(300);
    check(up_cnt > 0, "R5 slow feedback gives up", up_cnt, 1);
    check(dn_cnt == 0, "R5 slow feedback no dn", dn_cnt, 0);
  endtask

  task automatic t_quarter();
    step_sel = 0; txrx_n = 0; n_code = 9'd4; corr_en = 0;
    wait_clk(200);
    check(lock == 0, "R3 quarter step rejects N=4", lock, 0);
    n_code = 9'd8; corr_en = 1;
    wait_clk(4000);
    check(lock == 1, "R3 R4 lock at quarter step N=8", lock, 1);
  endtask

  task automatic t_illegal(input logic [8:0] code);
    n_code = code;
    wait_clk(3);
    check(inhibit == 1, "R10 illegal code inhibits", inhibit, 1);
    check(lock == 0, "R10 illegal code unlocks", lock, 0);
    wait_clk(150);
    clear_counts();
    wait_clk(300);
    check(dn_cnt == 0, "R10 no feedback ticks", dn_cnt, 0);
  endtask

  task automatic t_recover();
    n_code = 9'd8; corr_en = 1;
    wait_clk(4000);
    check(lock == 1, "R10 relock after legal code", lock, 1);
    check(inhibit == 0, "R9 inhibit released again", inhibit, 0);
  endtask

  initial begin
    t_reset();
    t_base_lock();
    t_tx_ignored();
    t_fast_fb();
    t_half_lock();
    t_slow_fb();
    t_quarter();
    t_illegal(9'd1);
    t_illegal(9'd0);
    t_recover();
    check(cmp_bad == 0, "R8 lock_no complement", cmp_bad, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule